// File: doc/BRIEF.md
# Tile Remote Memory Write Port

This block sits beside the core of one tile in a mesh of tiles. Any tile can write straight into the instruction store or the data store of any tile, itself included, without a handshake and without telling the receiver who sent the data. On the send side the core issues one flit per send instruction: a header, an address, one or more data words, and a tail. The block registers each flit and forwards it to the mesh on the next cycle. When the flit is a header, the block packs the destination coordinates and the target-store select into its payload.

On the receive side a small packet decoder follows the header, address, data and tail order. It drives the write strobes of the local instruction or data store directly, so the core is never interrupted. Each data flit writes to the next consecutive word. A flit that breaks the order is discarded, and the decoder returns to looking for a header. When a data-store packet's tail arrives, an arrival flag is latched. A core stalled on wait-for-data is released from that flag, whether the packet came before or after the wait was issued. A network write to the data store takes the store port ahead of a core store in the same cycle. The core store is held off by dropping its ready signal for that cycle.

Top module: `tileMsgPort`

## Requirements
- R1: A flit offered on the send inputs appears on the mesh outputs in the following cycle, with its flit code unchanged (0 header, 1 address, 2 data, 3 tail). For non-header flits the payload is forwarded unchanged. With no send offered, txValid is low the next cycle.
- R2: For a header flit the forwarded payload carries destination X in bits 3:0, destination Y in bits 7:4, and the target select in bit 8 (1 = instruction store, 0 = data store). All other bits are zero.
- R3: After a header and an address flit, each data flit writes its payload in the same cycle, starting at the address-flit word address and moving to the next consecutive address for each further data flit. The store written is the one picked by header bit 8, and the address wraps at the store size.
- R4: A packet aimed at the instruction store causes no data-store write, and a packet aimed at the data store causes no instruction-store write.
- R5: A flit that arrives out of order is dropped without any write: a non-header while waiting for a header, a non-address after a header, or a header or address inside a packet body. Once dropped, the decoder waits for a new header.
- R6: The tail of a data-store packet latches an arrival. A wait-for-data issued later completes in the same cycle it is raised. A tail of an instruction-store packet latches nothing.
- R7: With wait-for-data already raised, waitDone stays low until a data-store tail arrives and goes high in the cycle after that tail flit.
- R8: When a network data-store write and a core store fall in the same cycle, the store port carries the network write and coreStReady is low. In a cycle with no network data-store write, coreStReady is high and the port carries the core store.
- R9: After reset, txValid, imemWe, dmemWe and waitDone are low and coreStReady is high.
- R10: Each release consumes the latched arrival. Several data-store tails received before a wait give a single one-cycle release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sendValid | input | 1 | Core issues a send flit this cycle |
| sendType | input | 2 | Flit code of the send flit |
| sendToImem | input | 1 | Send targets the remote instruction store (used on header) |
| sendDestX | input | COORD_W | Destination column (used on header) |
| sendDestY | input | COORD_W | Destination row (used on header) |
| sendPayload | input | DATA_W | Address or data word of the send flit |
| txValid | output | 1 | Flit valid toward the mesh |
| txType | output | 2 | Flit code toward the mesh |
| txData | output | DATA_W | Flit payload toward the mesh |
| rxValid | input | 1 | Flit arriving from the mesh |
| rxType | input | 2 | Flit code of the arriving flit |
| rxData | input | DATA_W | Payload of the arriving flit |
| imemWe | output | 1 | Instruction-store write enable |
| imemAddr | output | IMEM_AW | Instruction-store word address |
| imemData | output | DATA_W | Instruction-store write data |
| dmemWe | output | 1 | Data-store write enable |
| dmemAddr | output | DMEM_AW | Data-store word address |
| dmemData | output | DATA_W | Data-store write data |
| coreStValid | input | 1 | Core requests a data-store write |
| coreStAddr | input | DMEM_AW | Core store address |
| coreStData | input | DATA_W | Core store data |
| coreStReady | output | 1 | Core store accepted this cycle |
| waitReq | input | 1 | Core is stalled in wait-for-data |
| waitDone | output | 1 | Releases the stalled core |

## Verification
Send flits come out one cycle after they are offered, so the bench drives just after a rising edge and reads txValid, txType and txData just after the next one. Store writes from the receive side are combinational on the data flit, so they are sampled later in the same cycle and recorded at the falling edge into bench copies of both stores. These copies are compared against a model built from the packets sent. A release comes in the same cycle as a raised wait when an arrival is already latched, and in the cycle after the tail when the wait came first. Both cases are sampled in exactly those cycles, and the bench also confirms that the release has gone low one cycle later.

// File: rtl/tileMsgPkg.sv
`timescale 1ns/1ps
package tileMsgPkg;

  // Flit codes carried beside every payload
  typedef enum logic [1:0] {
    FLIT_HEAD = 2'd0,
    FLIT_ADDR = 2'd1,
    FLIT_DATA = 2'd2,
    FLIT_TAIL = 2'd3
  } flitKind_e;

  // Strobes from the receive control to the datapath
  typedef struct packed {
    logic takeHead;
    logic takeAddr;
    logic writeWord;
    logic tailDone;
  } rxStrobe_t;

endpackage

// File: rtl/tileMsgRxCtrl.sv
`timescale 1ns/1ps
module tileMsgRxCtrl
  import tileMsgPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxValid,
  input  flitKind_e rxKind,
  output rxStrobe_t strobe
);

  typedef enum logic [1:0] {
    WAIT_HEAD = 2'd0,
    WAIT_ADDR = 2'd1,
    IN_BODY   = 2'd2
  } rxState_e;

  rxState_e state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (rxValid) begin
      unique case (state)
        WAIT_HEAD: begin
          if (rxKind == FLIT_HEAD) begin
            strobe.takeHead = 1'b1;
            stateNext       = WAIT_ADDR;
          end
        end
        WAIT_ADDR: begin
          if (rxKind == FLIT_ADDR) begin
            strobe.takeAddr = 1'b1;
            stateNext       = IN_BODY;
          end else begin
            stateNext = WAIT_HEAD;
          end
        end
        IN_BODY: begin
          if (rxKind == FLIT_DATA) begin
            strobe.writeWord = 1'b1;
          end else if (rxKind == FLIT_TAIL) begin
            strobe.tailDone = 1'b1;
            stateNext       = WAIT_HEAD;
          end else begin
            stateNext = WAIT_HEAD;
          end
        end
        default: stateNext = WAIT_HEAD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= WAIT_HEAD;
    else       state <= stateNext;
  end

endmodule

// File: rtl/tileMsgDatapath.sv
`timescale 1ns/1ps
module tileMsgDatapath
  import tileMsgPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 9,
  parameter int COORD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  rxStrobe_t          strobe,
  input  logic [DATA_W-1:0]  rxData,
  input  logic               sendValid,
  input  flitKind_e          sendKind,
  input  logic               sendToImem,
  input  logic [COORD_W-1:0] sendDestX,
  input  logic [COORD_W-1:0] sendDestY,
  input  logic [DATA_W-1:0]  sendPayload,
  output logic               txValid,
  output logic [1:0]         txType,
  output logic [DATA_W-1:0]  txData,
  output logic               imemWe,
  output logic [IMEM_AW-1:0] imemAddr,
  output logic [DATA_W-1:0]  imemData,
  output logic               dmemWe,
  output logic [DMEM_AW-1:0] dmemAddr,
  output logic [DATA_W-1:0]  dmemData,
  input  logic               coreStValid,
  input  logic [DMEM_AW-1:0] coreStAddr,
  input  logic [DATA_W-1:0]  coreStData,
  output logic               coreStReady,
  input  logic               waitReq,
  output logic               waitDone
);

  localparam int AW      = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW;
  localparam int SEL_BIT = 2 * COORD_W;

  logic          toImem;
  logic [AW-1:0] wordAddr;
  logic          arrived;
  logic          netImemWr, netDmemWr, arrivalNow;
  logic [DATA_W-1:0] headerWord;

  // Receive-side context: target store and running word address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      toImem   <= 1'b0;
      wordAddr <= '0;
    end else begin
      if (strobe.takeHead)  toImem   <= rxData[SEL_BIT];
      if (strobe.takeAddr)  wordAddr <= rxData[AW-1:0];
      else if (strobe.writeWord) wordAddr <= wordAddr + AW'(1);
    end
  end

  assign netImemWr  = strobe.writeWord & toImem;
  assign netDmemWr  = strobe.writeWord & ~toImem;
  assign arrivalNow = strobe.tailDone & ~toImem;

  assign imemWe   = netImemWr;
  assign imemAddr = wordAddr[IMEM_AW-1:0];
  assign imemData = rxData;

  // Network write owns the data-store port; the core store waits
  assign coreStReady = ~netDmemWr;
  assign dmemWe      = netDmemWr | coreStValid;
  assign dmemAddr    = netDmemWr ? wordAddr[DMEM_AW-1:0] : coreStAddr;
  assign dmemData    = netDmemWr ? rxData : coreStData;

  // Arrival latch feeding the wait-for-data release
  assign waitDone = waitReq & arrived;

  always_ff @(posedge clk) begin
    if (!rstN) arrived <= 1'b0;
    else       arrived <= arrivalNow | (arrived & ~waitDone);
  end

  // Send side: header payload packing and one register stage
  always_comb begin
    headerWord                     = '0;
    headerWord[COORD_W-1:0]        = sendDestX;
    headerWord[SEL_BIT-1:COORD_W]  = sendDestY;
    headerWord[SEL_BIT]            = sendToImem;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txType  <= 2'd0;
      txData  <= '0;
    end else begin
      txValid <= sendValid;
      if (sendValid) begin
        txType <= sendKind;
        txData <= (sendKind == FLIT_HEAD) ? headerWord : sendPayload;
      end
    end
  end

endmodule

// File: rtl/tileMsgPort.sv
`timescale 1ns/1ps
module tileMsgPort
  import tileMsgPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 9,
  parameter int COORD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sendValid,
  input  logic [1:0]         sendType,
  input  logic               sendToImem,
  input  logic [COORD_W-1:0] sendDestX,
  input  logic [COORD_W-1:0] sendDestY,
  input  logic [DATA_W-1:0]  sendPayload,
  output logic               txValid,
  output logic [1:0]         txType,
  output logic [DATA_W-1:0]  txData,
  input  logic               rxValid,
  input  logic [1:0]         rxType,
  input  logic [DATA_W-1:0]  rxData,
  output logic               imemWe,
  output logic [IMEM_AW-1:0] imemAddr,
  output logic [DATA_W-1:0]  imemData,
  output logic               dmemWe,
  output logic [DMEM_AW-1:0] dmemAddr,
  output logic [DATA_W-1:0]  dmemData,
  input  logic               coreStValid,
  input  logic [DMEM_AW-1:0] coreStAddr,
  input  logic [DATA_W-1:0]  coreStData,
  output logic               coreStReady,
  input  logic               waitReq,
  output logic               waitDone
);

  rxStrobe_t strobe;

  tileMsgRxCtrl i_rxCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxValid (rxValid),
    .rxKind  (flitKind_e'(rxType)),
    .strobe  (strobe)
  );

  tileMsgDatapath #(
    .DATA_W  (DATA_W),
    .IMEM_AW (IMEM_AW),
    .DMEM_AW (DMEM_AW),
    .COORD_W (COORD_W)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rxData      (rxData),
    .sendValid   (sendValid),
    .sendKind    (flitKind_e'(sendType)),
    .sendToImem  (sendToImem),
    .sendDestX   (sendDestX),
    .sendDestY   (sendDestY),
    .sendPayload (sendPayload),
    .txValid     (txValid),
    .txType      (txType),
    .txData      (txData),
    .imemWe      (imemWe),
    .imemAddr    (imemAddr),
    .imemData    (imemData),
    .dmemWe      (dmemWe),
    .dmemAddr    (dmemAddr),
    .dmemData    (dmemData),
    .coreStValid (coreStValid),
    .coreStAddr  (coreStAddr),
    .coreStData  (coreStData),
    .coreStReady (coreStReady),
    .waitReq     (waitReq),
    .waitDone    (waitDone)
  );

endmodule

// File: rtl/tileMsgChecker.sv
`timescale 1ns/1ps
module tileMsgChecker (
  input logic       clk,
  input logic       rstN,
  input logic       sendValid,
  input logic [1:0] sendType,
  input logic       txValid,
  input logic [1:0] txType,
  input logic       rxValid,
  input logic [1:0] rxType,
  input logic       imemWe,
  input logic       dmemWe,
  input logic       coreStValid,
  input logic       coreStReady,
  input logic       waitReq,
  input logic       waitDone
);

  assert_tx_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    sendValid |=> txValid && txType == $past(sendType));

  assert_tx_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !sendValid |=> !txValid);

  assert_imem_on_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    imemWe |-> rxValid && rxType == 2'd2);

  assert_one_store_R4: assert property (@(posedge clk) disable iff (!rstN)
    imemWe |-> !dmemWe || coreStValid);

  assert_store_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    coreStValid && !coreStReady |-> dmemWe && rxValid && rxType == 2'd2);

  assert_release_needs_wait_R7: assert property (@(posedge clk) disable iff (!rstN)
    waitDone |-> waitReq);

  assert_single_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    waitDone |=> !waitDone || ($past(rxValid) && $past(rxType) == 2'd3));

endmodule

bind tileMsgPort tileMsgChecker i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sendValid   (sendValid),
  .sendType    (sendType),
  .txValid     (txValid),
  .txType      (txType),
  .rxValid     (rxValid),
  .rxType      (rxType),
  .imemWe      (imemWe),
  .dmemWe      (dmemWe),
  .coreStValid (coreStValid),
  .coreStReady (coreStReady),
  .waitReq     (waitReq),
  .waitDone    (waitDone)
);

// File: tb/test_tileMsgPort.sv
`timescale 1ns/1ps
module test_tileMsgPort;

  localparam int DATA_W = 32, IMEM_AW = 8, DMEM_AW = 9, COORD_W = 4;
  localparam int IMEM_N = 1 << IMEM_AW;
  localparam int DMEM_N = 1 << DMEM_AW;
  localparam logic [1:0] K_HEAD = 2'd0, K_ADDR = 2'd1, K_DATA = 2'd2, K_TAIL = 2'd3;

  logic clk = 1'b0, rstN = 1'b0;
  logic sendValid = 0, sendToImem = 0;
  logic [1:0] sendType = 0;
  logic [COORD_W-1:0] sendDestX = 0, sendDestY = 0;
  logic [DATA_W-1:0] sendPayload = 0;
  logic txValid; logic [1:0] txType; logic [DATA_W-1:0] txData;
  logic rxValid = 0; logic [1:0] rxType = 0; logic [DATA_W-1:0] rxData = 0;
  logic imemWe, dmemWe, coreStReady, waitDone;
  logic [IMEM_AW-1:0] imemAddr; logic [DMEM_AW-1:0] dmemAddr;
  logic [DATA_W-1:0] imemData, dmemData;
  logic coreStValid = 0, waitReq = 0;
  logic [DMEM_AW-1:0] coreStAddr = 0; logic [DATA_W-1:0] coreStData = 0;

  always #4 clk = ~clk;

  tileMsgPort i_tileMsgPort (.*);

  int nChecks = 0, nFail = 0;
  int imemWrCnt = 0, dmemWrCnt = 0;
  logic [DATA_W-1:0] capImem [IMEM_N];
  logic [DATA_W-1:0] capDmem [DMEM_N];
  logic [DATA_W-1:0] expImem [IMEM_N];
  logic [DATA_W-1:0] expDmem [DMEM_N];

  always @(negedge clk) begin
    if (rstN && imemWe) begin capImem[imemAddr] = imemData; imemWrCnt++; end
    if (rstN && dmemWe) begin capDmem[dmemAddr] = dmemData; dmemWrCnt++; end
  end

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] headWord(logic imem, logic [COORD_W-1:0] x,
                                                logic [COORD_W-1:0] y);
    logic [DATA_W-1:0] w = '0;
    w[3:0] = x; w[7:4] = y; w[8] = imem;
    return w;
  endfunction

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic rxFlit(logic [1:0] k, logic [DATA_W-1:0] d);
    rxValid = 1; rxType = k; rxData = d;
    tick();
    rxValid = 0;
  endtask

  task automatic rxPacket(logic imem, int base, int len, bit gaps);
    rxFlit(K_HEAD, headWord(imem, 4'($urandom), 4'($urandom)));
    if (gaps && $urandom_range(1, 0) == 1) tick();
    rxFlit(K_ADDR, DATA_W'(base));
    for (int i = 0; i < len; i++) begin
      logic [DATA_W-1:0] d = $urandom;
      if (imem) expImem[(base + i) % IMEM_N] = d;
      else      expDmem[(base + i) % DMEM_N] = d;
      if (gaps && $urandom_range(2, 0) == 0) tick();
      rxFlit(K_DATA, d);
    end
    rxFlit(K_TAIL, $urandom);
  endtask

  task automatic sendOne(logic [1:0] k, logic imem, logic [3:0] x, logic [3:0] y,
                         logic [DATA_W-1:0] p);
    logic [DATA_W-1:0] expData;
    sendValid = 1; sendType = k; sendToImem = imem;
    sendDestX = x; sendDestY = y; sendPayload = p;
    expData = (k == K_HEAD) ? headWord(imem, x, y) : p;
    tick();
    sendValid = 0;
    check("R1 txValid", 32'(txValid), 32'd1);
    check("R1 txType", 32'(txType), 32'(k));
    check((k == K_HEAD) ? "R2 header payload" : "R1 payload", txData, expData);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    int wBefore, iBefore, mism;
    void'($urandom(32'd4242));
    for (int i = 0; i < IMEM_N; i++) begin capImem[i] = '0; expImem[i] = '0; end
    for (int i = 0; i < DMEM_N; i++) begin capDmem[i] = '0; expDmem[i] = '0; end

    // R9 reset state
    repeat (3) @(posedge clk);
    #2;
    check("R9 txValid", 32'(txValid), 0);
    check("R9 imemWe", 32'(imemWe), 0);
    check("R9 dmemWe", 32'(dmemWe), 0);
    check("R9 waitDone", 32'(waitDone), 0);
    check("R9 coreStReady", 32'(coreStReady), 1);
    @(posedge clk); #1 rstN = 1;
    tick();

    // R1 / R2 directed, then random sends
    sendOne(K_HEAD, 1'b1, 4'd3, 4'd5, 32'hFFFF_FFFF);
    check("R2 exact header", txData, 32'h0000_0153);
    sendOne(K_ADDR, 1'b0, 4'd0, 4'd0, 32'h0000_0044);
    sendOne(K_DATA, 1'b0, 4'd0, 4'd0, 32'hCAFE_F00D);
    sendOne(K_TAIL, 1'b0, 4'd0, 4'd0, 32'h1234_5678);
    tick();
    check("R1 idle txValid", 32'(txValid), 0);
    for (int n = 0; n < 20; n++)
      sendOne(2'($urandom), 1'($urandom), 4'($urandom), 4'($urandom), $urandom);
    tick();

    // R3 data-store packet with same-cycle write timing
    rxFlit(K_HEAD, headWord(1'b0, 4'd1, 4'd2));
    rxFlit(K_ADDR, 32'd10);
    rxValid = 1; rxType = K_DATA; rxData = 32'hA0A0_0001;
    #1;
    check("R3 dmemWe same cycle", 32'(dmemWe), 1);
    check("R3 dmemAddr", 32'(dmemAddr), 32'd10);
    expDmem[10] = 32'hA0A0_0001;
    tick(); rxValid = 0;
    expDmem[11] = 32'hA0A0_0002; rxFlit(K_DATA, 32'hA0A0_0002);
    expDmem[12] = 32'hA0A0_0003; rxFlit(K_DATA, 32'hA0A0_0003);
    rxFlit(K_TAIL, 0);
    check("R3 word 11", capDmem[11], 32'hA0A0_0002);
    check("R3 word 12", capDmem[12], 32'hA0A0_0003);

    // R4 instruction-store packet leaves the data store alone, wraps at top
    wBefore = dmemWrCnt;
    expImem[255] = 32'h1111_0001; expImem[0] = 32'h1111_0002;
    rxFlit(K_HEAD, headWord(1'b1, 4'd0, 4'd0));
    rxFlit(K_ADDR, 32'd255);
    rxFlit(K_DATA, 32'h1111_0001);
    rxFlit(K_DATA, 32'h1111_0002);
    rxFlit(K_TAIL, 0);
    check("R4 no dmem write", 32'(dmemWrCnt), 32'(wBefore));
    check("R3 imem 255", capImem[255], 32'h1111_0001);
    check("R3 imem wrap 0", capImem[0], 32'h1111_0002);

    // R5 out-of-order flits are dropped
    wBefore = dmemWrCnt; iBefore = imemWrCnt;
    rxFlit(K_DATA, 32'hBAD0_0001);
    rxFlit(K_TAIL, 32'hBAD0_0002);
    rxFlit(K_HEAD, headWord(1'b0, 4'd0, 4'd0));
    rxFlit(K_DATA, 32'hBAD0_0003);
    rxFlit(K_ADDR, 32'd40);
    rxFlit(K_DATA, 32'hBAD0_0004);
    rxFlit(K_HEAD, headWord(1'b0, 4'd0, 4'd0));
    rxFlit(K_ADDR, 32'd41);
    rxFlit(K_ADDR, 32'd42);
    rxFlit(K_DATA, 32'hBAD0_0005);
    check("R5 no dmem write", 32'(dmemWrCnt), 32'(wBefore));
    check("R5 no imem write", 32'(imemWrCnt), 32'(iBefore));
    rxPacket(1'b0, 60, 2, 1'b0);
    check("R5 recovery write", capDmem[61], expDmem[61]);

    // R8 network write beats a core store in the same cycle
    rxFlit(K_HEAD, headWord(1'b0, 4'd0, 4'd0));
    rxFlit(K_ADDR, 32'd200);
    rxValid = 1; rxType = K_DATA; rxData = 32'h5EED_0200;
    coreStValid = 1; coreStAddr = 9'd100; coreStData = 32'hC0DE_0100;
    #1;
    check("R8 ready low", 32'(coreStReady), 0);
    check("R8 port addr net", 32'(dmemAddr), 32'd200);
    check("R8 port data net", dmemData, 32'h5EED_0200);
    expDmem[200] = 32'h5EED_0200;
    tick(); rxValid = 0;
    #1;
    check("R8 ready high", 32'(coreStReady), 1);
    check("R8 port addr core", 32'(dmemAddr), 32'd100);
    expDmem[100] = 32'hC0DE_0100;
    tick(); coreStValid = 0;
    rxFlit(K_TAIL, 0);
    check("R8 store landed", capDmem[100], 32'hC0DE_0100);

    // R10 several tails gave one latched arrival: one release, then none
    waitReq = 1; #1;
    check("R10 first release", 32'(waitDone), 1);
    tick();
    check("R10 consumed", 32'(waitDone), 0);
    waitReq = 0;

    // R6 instruction-store tail latches nothing
    rxPacket(1'b1, 7, 1, 1'b0);
    waitReq = 1; #1;
    check("R6 imem tail no release", 32'(waitDone), 0);
    tick(); waitReq = 0;

    // R6 arrival before wait: immediate release
    rxPacket(1'b0, 300, 1, 1'b0);
    tick(); tick();
    waitReq = 1; #1;
    check("R6 immediate release", 32'(waitDone), 1);
    tick();
    check("R10 release one cycle", 32'(waitDone), 0);

    // R7 wait raised first; release the cycle after the tail
    rxFlit(K_HEAD, headWord(1'b0, 4'd0, 4'd0));
    check("R7 low during packet", 32'(waitDone), 0);
    rxFlit(K_ADDR, 32'd310);
    expDmem[310] = 32'h7777_0310;
    rxFlit(K_DATA, 32'h7777_0310);
    check("R7 low before tail", 32'(waitDone), 0);
    rxFlit(K_TAIL, 0);
    check("R7 release after tail", 32'(waitDone), 1);
    tick();
    check("R7 release ends", 32'(waitDone), 0);
    waitReq = 0;

    // Random packets with gaps and stray flits
    for (int n = 0; n < 40; n++) begin
      if ($urandom_range(3, 0) == 0) rxFlit(K_DATA, $urandom);
      rxPacket(1'($urandom), int'($urandom_range(DMEM_N - 1, 0)),
               int'($urandom_range(6, 1)), 1'b1);
      if ($urandom_range(1, 0) == 1) tick();
    end
    tick();

    mism = 0;
    for (int i = 0; i < IMEM_N; i++) if (capImem[i] !== expImem[i]) mism++;
    check("R3 imem contents", 32'(mism), 0);
    mism = 0;
    for (int i = 0; i < DMEM_N; i++) if (capDmem[i] !== expDmem[i]) mism++;
    check("R3 dmem contents", 32'(mism), 0);

    finishRun();
  end

endmodule